// File: doc/BRIEF.md
# Asynchronous ROM Read Controller

This block sits on the host side of a slow parallel ROM that has no clock of its own. A synchronous client raises a one-cycle request with an 11-bit address. The controller drives that address together with an active-low chip select and an active-low read enable. It holds them for a wait derived from the memory's access-time limits, samples the 8-bit data and returns it with a one-cycle valid pulse. It then releases the read enable and stays busy for a float interval, so that another device on the shared data lines cannot drive them while the ROM is still turning its drivers off.

The memory has three independent delay paths to valid data: from an address change, from chip select falling and from read enable falling. Data is good only after the slowest of the paths that were restarted by the access. When chip select is already low (state `ST_IDLE`), the access restarts the address and read-enable paths. When the part sits in standby (state `ST_STANDBY`, chip select high), the access restarts the chip-select and read-enable paths. The controller loads the wait that matches the case it is in. After a programmable number of idle cycles with no request, it raises chip select and the memory goes into standby.

The states are `ST_STANDBY`, `ST_IDLE`, `ST_ACCESS` and `ST_FLOAT`. The transitions are:
- standby→access on a request;
- idle→access on a request;
- idle→standby when the idle timer expires;
- access→float at the capture edge;
- float→idle when the float timer expires.

Reset enters `ST_STANDBY`. Wait lengths are ceiling(ns / clock period). A grade parameter selects the 350 ns or the 450 ns access limit.

Top module: `arom_rd_ctrl`

## Requirements
- R1: While reset is applied and directly after it, chip select is high, read enable is high, busy is low and the valid pulse is low.
- R2: A request taken while busy is low makes the next cycle show chip select low, read enable low, busy high, and the ROM address output equal to the requested address.
- R3: The valid pulse rises exactly N cycles after the accepting edge and lasts one cycle. N is the larger of ceil(address or chip-select limit / period) and ceil(120 ns / period). The access limit is 350 ns when the fast-grade parameter is 1 and 450 ns otherwise. An access from standby uses the chip-select limit, and an access from idle uses the address limit.
- R4: The returned data equals the ROM data sampled at the last edge of the wait. The ROM address output stays unchanged from acceptance through that edge.
- R5: Read enable goes high at the capture edge, so it is high whenever the valid pulse is high.
- R6: After the capture edge, busy stays high for F = ceil(100 ns / period) cycles, then falls.
- R7: A request made while busy is high is dropped. The ROM address output keeps the current address and no extra valid pulse appears.
- R8: After an access, chip select stays low while idle. Once IDLE_CYC idle cycles pass with no request, chip select goes high (standby). A request arriving before that keeps chip select low.
- R9: Read enable is never low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Read request, sampled when busy is low |
| addr_i | input | 11 | Requested ROM address |
| busy_o | output | 1 | Access or float interval in progress |
| rdata_o | output | 8 | Captured read data |
| rvalid_o | output | 1 | One-cycle pulse marking rdata_o valid |
| rom_addr_o | output | 11 | Address to the ROM |
| rom_ce_n_o | output | 1 | Active-low chip select to the ROM |
| rom_oe_n_o | output | 1 | Active-low read enable to the ROM |
| rom_data_i | input | 8 | Data lines from the ROM |

## Verification
The results are due at these cycles, counted from the edge that accepts a request:
- The ROM-side strobes and busy change one cycle after that edge.
- The valid pulse and data are due N cycles after it.
- Busy falls F cycles after the capture edge.
- Standby starts IDLE_CYC cycles after idle is entered.

The bench counts its sampling points from the accepting edge and takes every sample on the falling clock edge. The bench ROM model returns corrupted data until each of its three delay paths has aged past its limit, counted in whole observed cycles. An early capture therefore shows up as a data mismatch rather than passing by chance.

// File: rtl/arom_pkg.sv
package arom_pkg;

    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_IDLE    = 2'd1,
        ST_ACCESS  = 2'd2,
        ST_FLOAT   = 2'd3
    } arom_state_e;

    function automatic int unsigned cyc_ceil(input int unsigned ns, input int unsigned per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int unsigned cyc_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/arom_cnt.sv
module arom_cnt #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic          last_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == CW'(1));

endmodule

// File: rtl/arom_dpath.sv
module arom_dpath #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_i,
    input  logic [AW-1:0] addr_i,
    input  logic          capture_i,
    input  logic [DW-1:0] rom_data_i,
    output logic [AW-1:0] rom_addr_o,
    output logic [DW-1:0] rdata_o,
    output logic          rvalid_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_addr_o <= '0;
            rdata_o    <= '0;
            rvalid_o   <= 1'b0;
        end else begin
            if (accept_i) begin
                rom_addr_o <= addr_i;
            end
            if (capture_i) begin
                rdata_o <= rom_data_i;
            end
            rvalid_o <= capture_i;
        end
    end

endmodule

// File: rtl/arom_rd_ctrl.sv
module arom_rd_ctrl
    import arom_pkg::*;
#(
    parameter int unsigned CLK_NS     = 10,
    parameter bit          FAST_GRADE = 1'b1,
    parameter int unsigned T_FAST_NS  = 350,
    parameter int unsigned T_STD_NS   = 450,
    parameter int unsigned T_OE_NS    = 120,
    parameter int unsigned T_FLOAT_NS = 100,
    parameter bit          IDLE_EN    = 1'b1,
    parameter int unsigned IDLE_CYC   = 20,
    parameter int          AW         = 11,
    parameter int          DW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [AW-1:0] addr_i,
    output logic          busy_o,
    output logic [DW-1:0] rdata_o,
    output logic          rvalid_o,
    output logic [AW-1:0] rom_addr_o,
    output logic          rom_ce_n_o,
    output logic          rom_oe_n_o,
    input  logic [DW-1:0] rom_data_i
);

    localparam int unsigned T_ACC_NS  = FAST_GRADE ? T_FAST_NS : T_STD_NS;
    localparam int unsigned T_CE_NS   = FAST_GRADE ? T_FAST_NS : T_STD_NS;
    localparam int unsigned OE_CYC    = cyc_ceil(T_OE_NS, CLK_NS);
    localparam int unsigned WAIT_ADDR = cyc_max(cyc_ceil(T_ACC_NS, CLK_NS), OE_CYC);
    localparam int unsigned WAIT_CE   = cyc_max(cyc_ceil(T_CE_NS, CLK_NS), OE_CYC);
    localparam int unsigned FLOAT_RAW = cyc_ceil(T_FLOAT_NS, CLK_NS);
    localparam int unsigned FLOAT_CYC = (FLOAT_RAW == 0) ? 1 : FLOAT_RAW;
    localparam int unsigned TMR_MAX   = cyc_max(cyc_max(WAIT_ADDR, WAIT_CE), FLOAT_CYC);
    localparam int          TW        = $clog2(TMR_MAX + 1);
    localparam int          IW        = $clog2(IDLE_CYC + 1);

    arom_state_e state_q, state_d;

    logic          accept;
    logic          capture;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_last;
    logic          idle_last;

    assign accept  = req_i && ((state_q == ST_STANDBY) || (state_q == ST_IDLE));
    assign capture = (state_q == ST_ACCESS) && tmr_last;

    // One shared timer covers both the access wait and the float interval
    assign tmr_load = accept || capture;
    always_comb begin
        if (accept) begin
            tmr_val = (state_q == ST_STANDBY) ? TW'(WAIT_CE) : TW'(WAIT_ADDR);
        end else begin
            tmr_val = TW'(FLOAT_CYC);
        end
    end

    arom_cnt #(.CW(TW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .last_o (tmr_last)
    );

    generate
        if (IDLE_EN) begin : g_idle
            logic idle_load;
            assign idle_load = (state_d == ST_IDLE) && (state_q != ST_IDLE);
            arom_cnt #(.CW(IW)) u_idle (
                .clk    (clk),
                .rst_n  (rst_n),
                .load_i (idle_load),
                .val_i  (IW'(IDLE_CYC)),
                .last_o (idle_last)
            );
        end else begin : g_no_idle
            assign idle_last = 1'b0;
        end
    endgenerate

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STANDBY: if (req_i) state_d = ST_ACCESS;
            ST_IDLE: begin
                if (req_i)          state_d = ST_ACCESS;
                else if (idle_last) state_d = ST_STANDBY;
            end
            ST_ACCESS:  if (tmr_last) state_d = ST_FLOAT;
            ST_FLOAT:   if (tmr_last) state_d = ST_IDLE;
            default:    state_d = ST_STANDBY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STANDBY;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        rom_ce_n_o = 1'b0;
        rom_oe_n_o = 1'b1;
        busy_o     = 1'b0;
        unique case (state_q)
            ST_STANDBY: rom_ce_n_o = 1'b1;
            ST_IDLE:    ;
            ST_ACCESS: begin
                rom_oe_n_o = 1'b0;
                busy_o     = 1'b1;
            end
            ST_FLOAT:   busy_o = 1'b1;
            default:    rom_ce_n_o = 1'b1;
        endcase
    end

    arom_dpath #(.AW(AW), .DW(DW)) u_dpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .addr_i     (addr_i),
        .capture_i  (capture),
        .rom_data_i (rom_data_i),
        .rom_addr_o (rom_addr_o),
        .rdata_o    (rdata_o),
        .rvalid_o   (rvalid_o)
    );

endmodule

// File: rtl/arom_chk.sv
module arom_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_i,
    input logic          busy_o,
    input logic          rvalid_o,
    input logic [AW-1:0] rom_addr_o,
    input logic          rom_ce_n_o,
    input logic          rom_oe_n_o
);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (rom_ce_n_o && rom_oe_n_o && !busy_o && !rvalid_o)); // R1
    AST_ACCEPT_STROBES: assert property (@(posedge clk) disable iff (!rst_n) (req_i && !busy_o) |=> (!rom_ce_n_o && !rom_oe_n_o && busy_o)); // R2
    AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rvalid_o |=> !rvalid_o); // R3
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!rom_oe_n_o && !$past(rom_oe_n_o)) |-> $stable(rom_addr_o)); // R4
    AST_VALID_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) rvalid_o |-> rom_oe_n_o); // R5
    AST_BUSY_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n) busy_o |=> $stable(rom_addr_o)); // R7
    AST_STANDBY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) rom_ce_n_o |-> !busy_o); // R8
    AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n) !rom_oe_n_o |-> !rom_ce_n_o); // R9

endmodule

bind arom_rd_ctrl arom_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .busy_o     (busy_o),
    .rvalid_o   (rvalid_o),
    .rom_addr_o (rom_addr_o),
    .rom_ce_n_o (rom_ce_n_o),
    .rom_oe_n_o (rom_oe_n_o)
);

// File: tb/sim_arom_rd_ctrl.sv
module sim_arom_rd_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int T_ACC   = 350;
    localparam int T_OE    = 120;
    localparam int T_FLT   = 100;
    localparam int IDLE_N  = 20;

    function automatic int ceil_cyc(input int ns);
        return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    endfunction

    localparam int N_WAIT = (ceil_cyc(T_ACC) > ceil_cyc(T_OE)) ? ceil_cyc(T_ACC) : ceil_cyc(T_OE);
    localparam int F_WAIT = ceil_cyc(T_FLT);

    function automatic logic [7:0] rom_val(input logic [10:0] a);
        return a[7:0] ^ {a[10:8], 5'b10110};
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [10:0] addr = '0;
    logic        busy, rvalid, ce_n, oe_n;
    logic [7:0]  rdata, rom_data;
    logic [10:0] rom_addr;

    int n_chk = 0;
    int n_bad = 0;
    int idle_seen = 100000;

    always #(CLK_PERIOD / 2) clk = ~clk;

    arom_rd_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .addr_i     (addr),
        .busy_o     (busy),
        .rdata_o    (rdata),
        .rvalid_o   (rvalid),
        .rom_addr_o (rom_addr),
        .rom_ce_n_o (ce_n),
        .rom_oe_n_o (oe_n),
        .rom_data_i (rom_data)
    );

    // ROM model: each delay path ages in whole observed cycles
    int age_a = 0, age_ce = 0, age_oe = 0;
    logic [10:0] prev_a = '0;
    logic prev_ce = 1'b1, prev_oe = 1'b1;

    always @(negedge clk) begin
        age_a  <= (rom_addr != prev_a) ? 1 : ((age_a < 1000) ? age_a + 1 : age_a);
        age_ce <= (ce_n || prev_ce) ? (ce_n ? 0 : 1) : ((age_ce < 1000) ? age_ce + 1 : age_ce);
        age_oe <= (oe_n || prev_oe) ? (oe_n ? 0 : 1) : ((age_oe < 1000) ? age_oe + 1 : age_oe);
        prev_a  <= rom_addr;
        prev_ce <= ce_n;
        prev_oe <= oe_n;
    end

    always_comb begin
        if (!ce_n && !oe_n && (age_a * CLK_PERIOD >= T_ACC) &&
            (age_ce * CLK_PERIOD >= T_ACC) && (age_oe * CLK_PERIOD >= T_OE))
            rom_data = rom_val(rom_addr);
        else
            rom_data = ~rom_val(rom_addr);
    end

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // Starts and ends on a falling edge; gap = idle cycles before the request
    task automatic do_read(input logic [10:0] a, input int gap, input bit intr);
        int extra_valid = 0;
        bit addr_ok = 1'b1;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            idle_seen++;
        end
        check(ce_n == (idle_seen >= IDLE_N + 1), "R8", ce_n, (idle_seen >= IDLE_N + 1));
        req = 1'b1;
        addr = a;
        @(negedge clk);
        req = 1'b0;
        check(!ce_n && !oe_n && busy && rom_addr == a, "R2",
              {ce_n, oe_n, busy, 5'b0, rom_addr}, {3'b001, 5'b0, a});
        if (intr) begin
            req = 1'b1;
            addr = ~a;
        end
        for (int p = 1; p <= N_WAIT + F_WAIT; p++) begin
            @(negedge clk);
            req = 1'b0;
            if (p < N_WAIT && rom_addr != a) addr_ok = 1'b0;
            if (p == N_WAIT - 1) check(!rvalid, "R3", rvalid, 0);
            if (p == N_WAIT) begin
                check(rvalid, "R3", rvalid, 1);
                check(rdata == rom_val(a), "R4", rdata, rom_val(a));
                check(oe_n, "R5", oe_n, 1);
                check(rom_addr == a, "R7", rom_addr, a);
            end
            if (p > N_WAIT && rvalid) extra_valid++;
            if (p == N_WAIT + F_WAIT - 1) check(busy, "R6", busy, 1);
            if (p == N_WAIT + F_WAIT) check(!busy, "R6", busy, 0);
        end
        check(addr_ok, "R4", addr_ok, 1);
        check(extra_valid == 0, "R7", extra_valid, 0);
        idle_seen = 1;
    endtask

    initial begin
        void'($urandom(32'h1D2C));
        repeat (3) @(negedge clk);
        check(ce_n && oe_n && !busy && !rvalid, "R1", {ce_n, oe_n, busy, rvalid}, 4'b1100);
        rst_n = 1'b1;
        @(negedge clk);
        check(ce_n && oe_n && !busy && !rvalid, "R1", {ce_n, oe_n, busy, rvalid}, 4'b1100);
        // directed: from standby, back-to-back from idle, edge of standby entry
        do_read(11'h000, 0, 1'b0);
        do_read(11'h7FF, 0, 1'b0);
        do_read(11'h2A5, IDLE_N - 1, 1'b1);
        do_read(11'h15A, IDLE_N, 1'b0);
        // R8: standby entry observed directly
        repeat (IDLE_N - 1) @(negedge clk);
        check(!ce_n, "R8", ce_n, 0);
        @(negedge clk);
        check(ce_n && oe_n, "R8", {ce_n, oe_n}, 2'b11);
        idle_seen = IDLE_N + 1;
        for (int i = 0; i < 60; i++) begin
            do_read(11'($urandom), int'($urandom_range(0, 30)), 1'($urandom));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // R9 continuous observation at the ports
    always @(negedge clk) begin
        if (rst_n && !oe_n && ce_n) begin
            n_chk++;
            n_bad++;
            $display("FAIL R9: actual ce_n %0h expected %0h", ce_n, 0);
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule